// File: doc/BRIEF.md
# Replaying Flit Buffer for a Switch Input Port

This block is one input port of an on-chip packet switch that finds corruption end to end and heals it by resending. Arriving flits are written into a circular store. A launch pointer hands them, one per granted cycle, into a model of the switch pipeline whose depth is a parameter. A third pointer, the commit mark, trails behind. Flits between the commit mark and the launch pointer have been sent but not yet confirmed, and they keep their slots.

At the pipeline exit a CRC-16 unit folds the data of each header and body flit and compares the result with the value carried in the tail flit. A match confirms the packet: the commit mark moves past its tail and the slots are freed. A mismatch raises an error pulse. A recovery broadcast from elsewhere in the switch has the same effect. Either event discards the packet in progress at the output, empties the pipeline and rewinds the launch pointer to the commit mark, so the unconfirmed flits go out again in their original order. A fault-injection mask on the launch path lets a single bit upset be placed in a chosen flit.

Top module: `rbk_replay_port`

## Requirements
- R1: While reset is held and after its release, in_ready is 1 and out_valid, out_commit, out_drop and crc_err are 0 until traffic is offered.
- R2: A flit is stored when in_valid and in_ready are both 1. in_ready is 0 when the slot after the write pointer is the commit mark, so at most DEPTH-1 flits are held. A flit offered while in_ready is 0 is not stored.
- R3: While the buffer holds unlaunched flits and sw_grant is 1, one flit is launched per cycle in arrival order. A flit launched at a clock edge appears on out_valid/out_flit PIPE edges later.
- R4: A flit is {kind[1:0], data[DW-1:0]}, with the kind in bits [DW+1:DW]: 2'b01 header, 2'b00 body, 2'b10 tail. The check value is CRC-16 with polynomial 0x1021 and start value 0xFFFF, processed MSB first over the data of the header and body flits. It is carried in data[15:0] of the tail flit.
- R5: A tail whose carried value matches raises out_commit in the cycle it is on the output. The commit mark then moves past that tail, freeing its packet's slots. The commit mark moves on no other event.
- R6: A tail whose carried value does not match raises crc_err and out_drop for that one cycle, and never raises out_commit.
- R7: A rewind happens when crc_err or glob_err is 1. On a rewind the launch pointer is set to the commit mark and every flit in the pipeline is discarded, so out_valid is 0 in the next cycle. The CRC state is cleared, and replay starts from the oldest unconfirmed flit.
- R8: glob_err raises out_drop in the same cycle and suppresses out_commit, even for a matching tail; that packet is replayed.
- R9: Launched but unconfirmed flits keep their slots: launching alone does not raise in_ready.
- R10: pipe_upset is XORed into the data of the flit launched in that cycle.
- R11: After a rewind, every packet is delivered once, intact and in its original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Upstream flit valid |
| in_flit | input | DW+2 | Upstream flit {kind, data} |
| in_ready | output | 1 | Buffer can take a flit (back-pressure when low) |
| sw_grant | input | 1 | Switch allows a launch this cycle |
| pipe_upset | input | DW | Bit mask XORed into the launched flit's data |
| glob_err | input | 1 | Recovery broadcast: drop, flush and rewind |
| out_valid | output | 1 | Flit leaving the switch pipeline |
| out_flit | output | DW+2 | Flit leaving the switch pipeline |
| out_commit | output | 1 | Packet ending with this tail is confirmed |
| out_drop | output | 1 | Discard the packet in progress, including this cycle's flit |
| crc_err | output | 1 | Local CRC mismatch, sent to the recovery unit |

## Verification
On every cycle the assertions check several things. Back-pressure is raised only when the buffer is full, and a refused flit leaves the write pointer alone. The launch pointer stays between the commit mark and the write pointer. The commit mark moves only on a commit, and a drop never coincides with a commit. Every drop is followed by the launch pointer sitting on the old commit mark and by an empty output, and an error pulse only ever accompanies a tail flit. Only the bench's scenarios can show the end-to-end claims. These are the exact launch latency, the capacity count with a refused extra flit, intact in-order delivery after an injected bit flip, and replay caused by a broadcast error.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10
  } flit_kind_e;
endpackage

// File: rtl/rbk_flit_store.sv
module rbk_flit_store #(
  parameter int FW    = 18,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [FW-1:0] wr_flit,
  input  logic [AW-1:0] rd_idx,
  output logic [FW-1:0] rd_flit
);
  logic [FW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_idx] <= wr_flit;
    end
  end

  assign rd_flit = mem_q[rd_idx];
endmodule

// File: rtl/rbk_ptr_ctrl.sv
module rbk_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          launch,
  input  logic          commit,
  input  logic [AW-1:0] commit_idx,
  input  logic          rewind,
  output logic [AW-1:0] tail_ptr,
  output logic [AW-1:0] head_ptr,
  output logic [AW-1:0] rec_ptr,
  output logic          full,
  output logic          pending
);
  logic [AW-1:0] tail_n, head_n, rec_n;

  always_comb begin
    tail_n = tail_ptr;
    head_n = head_ptr;
    rec_n  = rec_ptr;
    if (wr_en) begin
      tail_n = tail_ptr + AW'(1);
    end
    if (rewind) begin
      head_n = rec_ptr;
    end else if (launch) begin
      head_n = head_ptr + AW'(1);
    end
    if (commit) begin
      rec_n = commit_idx + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_ptr <= '0;
      head_ptr <= '0;
      rec_ptr  <= '0;
    end else begin
      tail_ptr <= tail_n;
      head_ptr <= head_n;
      rec_ptr  <= rec_n;
    end
  end

  assign full    = ((tail_ptr + AW'(1)) == rec_ptr);
  assign pending = (head_ptr != tail_ptr);
endmodule

// File: rtl/rbk_switch_pipe.sv
module rbk_switch_pipe #(
  parameter int FW    = 18,
  parameter int PIPE  = 2,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_v,
  input  logic [FW-1:0] in_flit,
  input  logic [AW-1:0] in_idx,
  output logic          exit_v,
  output logic [FW-1:0] exit_flit,
  output logic [AW-1:0] exit_idx
);
  logic [PIPE-1:0] v_q, v_n;
  logic [FW-1:0]   f_q [PIPE];
  logic [FW-1:0]   f_n [PIPE];
  logic [AW-1:0]   i_q [PIPE];
  logic [AW-1:0]   i_n [PIPE];

  for (genvar s = 0; s < PIPE; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign v_n[s] = flush ? 1'b0 : in_v;
      assign f_n[s] = in_flit;
      assign i_n[s] = in_idx;
    end else begin : g_next
      assign v_n[s] = flush ? 1'b0 : v_q[s-1];
      assign f_n[s] = f_q[s-1];
      assign i_n[s] = i_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q <= v_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < PIPE; s++) begin
      if (v_n[s]) begin
        f_q[s] <= f_n[s];
        i_q[s] <= i_n[s];
      end
    end
  end

  assign exit_v    = v_q[PIPE-1];
  assign exit_flit = f_q[PIPE-1];
  assign exit_idx  = i_q[PIPE-1];
endmodule

// File: rtl/rbk_crc_check.sv
module rbk_crc_check
  import rbk_pkg::*;
#(
  parameter int             DW   = 16,
  parameter int             CW   = 16,
  parameter logic [CW-1:0]  POLY = 16'h1021,
  parameter logic [CW-1:0]  SEED = 16'hFFFF,
  localparam int            FW   = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          exit_v,
  input  logic [FW-1:0] exit_flit,
  output logic          tail_ok,
  output logic          tail_bad
);
  logic [CW-1:0] acc_q, acc_n, acc_base, acc_step;
  flit_kind_e    kind;
  logic [DW-1:0] data;

  function automatic logic [CW-1:0] fold(input logic [CW-1:0] c_in,
                                         input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic          fb;
    c = c_in;
    for (int b = DW - 1; b >= 0; b--) begin
      fb = c[CW-1] ^ d[b];
      c  = {c[CW-2:0], 1'b0};
      if (fb) begin
        c = c ^ POLY;
      end
    end
    return c;
  endfunction

  assign kind     = flit_kind_e'(exit_flit[FW-1:DW]);
  assign data     = exit_flit[DW-1:0];
  assign acc_base = (kind == FK_HEAD) ? SEED : acc_q;
  assign acc_step = fold(acc_base, data);

  assign tail_ok  = exit_v && (kind == FK_TAIL) && (acc_q == data[CW-1:0]);
  assign tail_bad = exit_v && (kind == FK_TAIL) && (acc_q != data[CW-1:0]);

  always_comb begin
    acc_n = acc_q;
    if (clear) begin
      acc_n = SEED;
    end else if (exit_v) begin
      acc_n = (kind == FK_TAIL) ? SEED : acc_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= SEED;
    end else begin
      acc_q <= acc_n;
    end
  end
endmodule

// File: rtl/rbk_replay_port.sv
module rbk_replay_port #(
  parameter int            DW    = 16,
  parameter int            DEPTH = 16,
  parameter int            PIPE  = 2,
  parameter int            CW    = 16,
  parameter logic [CW-1:0] POLY  = 16'h1021,
  parameter logic [CW-1:0] SEED  = 16'hFFFF,
  localparam int           FW    = DW + 2,
  localparam int           AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [FW-1:0] in_flit,
  output logic          in_ready,
  input  logic          sw_grant,
  input  logic [DW-1:0] pipe_upset,
  input  logic          glob_err,
  output logic          out_valid,
  output logic [FW-1:0] out_flit,
  output logic          out_commit,
  output logic          out_drop,
  output logic          crc_err
);
  logic [1:0]    rs_q;
  logic          rst_s;
  logic [AW-1:0] tail_ptr, head_ptr, rec_ptr, exit_idx;
  logic          full, pending, wr_en, launch, rewind;
  logic          tail_ok, tail_bad, exit_v;
  logic [FW-1:0] rd_flit, launch_flit, exit_flit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_s = rs_q[1];

  assign wr_en       = in_valid && !full;
  assign rewind      = tail_bad || glob_err;
  assign launch      = pending && sw_grant && !rewind;
  assign launch_flit = {rd_flit[FW-1:DW], rd_flit[DW-1:0] ^ pipe_upset};

  rbk_flit_store #(.FW(FW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (tail_ptr),
    .wr_flit (in_flit),
    .rd_idx  (head_ptr),
    .rd_flit (rd_flit)
  );

  rbk_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_s),
    .wr_en      (wr_en),
    .launch     (launch),
    .commit     (out_commit),
    .commit_idx (exit_idx),
    .rewind     (rewind),
    .tail_ptr   (tail_ptr),
    .head_ptr   (head_ptr),
    .rec_ptr    (rec_ptr),
    .full       (full),
    .pending    (pending)
  );

  rbk_switch_pipe #(.FW(FW), .PIPE(PIPE), .AW(AW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_s),
    .flush     (rewind),
    .in_v      (launch),
    .in_flit   (launch_flit),
    .in_idx    (head_ptr),
    .exit_v    (exit_v),
    .exit_flit (exit_flit),
    .exit_idx  (exit_idx)
  );

  rbk_crc_check #(.DW(DW), .CW(CW), .POLY(POLY), .SEED(SEED)) u_crc (
    .clk       (clk),
    .rst_n     (rst_s),
    .clear     (rewind),
    .exit_v    (exit_v),
    .exit_flit (exit_flit),
    .tail_ok   (tail_ok),
    .tail_bad  (tail_bad)
  );

  assign in_ready   = !full;
  assign out_valid  = exit_v;
  assign out_flit   = exit_flit;
  assign out_commit = tail_ok && !glob_err;
  assign out_drop   = rewind;
  assign crc_err    = tail_bad;
endmodule

// File: rtl/rbk_replay_port_chk.sv
module rbk_replay_port_chk #(
  parameter int  DW    = 16,
  parameter int  DEPTH = 16,
  localparam int FW    = DW + 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_s,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [FW-1:0] out_flit,
  input logic          out_commit,
  input logic          out_drop,
  input logic          crc_err,
  input logic [AW-1:0] tail_ptr,
  input logic [AW-1:0] head_ptr,
  input logic [AW-1:0] rec_ptr
);
  logic [AW-1:0] held, sent;
  assign held = tail_ptr - rec_ptr;
  assign sent = head_ptr - rec_ptr;

  AST_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_s)
    !in_ready |-> (held == AW'(DEPTH - 1))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && !in_ready) |=> $stable(tail_ptr)); // R2
  AST_HEAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_s)
    sent <= held); // R9
  AST_MARK_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !out_commit |=> $stable(rec_ptr)); // R5
  AST_ERR_ON_TAIL: assert property (@(posedge clk) disable iff (!rst_s)
    crc_err |-> (out_valid && out_flit[FW-1:DW] == 2'b10 && !out_commit)); // R6
  AST_DROP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_s)
    out_drop |-> !out_commit); // R8
  AST_REWIND_HEAD: assert property (@(posedge clk) disable iff (!rst_s)
    out_drop |=> (head_ptr == $past(rec_ptr))); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_s)
    out_drop |=> !out_valid); // R7
endmodule

bind rbk_replay_port rbk_replay_port_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_flit   (out_flit),
  .out_commit (out_commit),
  .out_drop   (out_drop),
  .crc_err    (crc_err),
  .tail_ptr   (tail_ptr),
  .head_ptr   (head_ptr),
  .rec_ptr    (rec_ptr)
);

// File: tb/test_rbk_replay_port.sv
module test_rbk_replay_port;
  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int PIPE  = 2;
  localparam int FW    = DW + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [FW-1:0] in_flit;
  logic          in_ready;
  logic          sw_grant;
  logic [DW-1:0] pipe_upset;
  logic          glob_err;
  logic          out_valid;
  logic [FW-1:0] out_flit;
  logic          out_commit;
  logic          out_drop;
  logic          crc_err;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;

  logic [FW-1:0] exp_q  [256];
  logic [FW-1:0] del_q  [256];
  logic [FW-1:0] part_q [32];
  logic [FW-1:0] log_q  [512];
  int n_exp = 0, n_del = 0, n_part = 0, n_log = 0, n_err = 0;

  always #5 clk = ~clk;

  rbk_replay_port #(.DW(DW), .DEPTH(DEPTH), .PIPE(PIPE)) i_rbk_replay_port (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .in_ready(in_ready), .sw_grant(sw_grant), .pipe_upset(pipe_upset),
    .glob_err(glob_err), .out_valid(out_valid), .out_flit(out_flit),
    .out_commit(out_commit), .out_drop(out_drop), .crc_err(crc_err)
  );

  // Receiver model: keeps a packet in progress, keeps it on commit, discards it on drop.
  always begin
    @(negedge clk);
    #4;
    if (mon_on) begin
      if (out_valid) begin
        log_q[n_log % 512] = out_flit;
        n_log++;
        part_q[n_part % 32] = out_flit;
        n_part++;
      end
      if (crc_err) n_err++;
      if (out_drop) begin
        n_part = 0;
      end else if (out_commit) begin
        for (int k = 0; k < n_part; k++) begin
          del_q[n_del % 256] = part_q[k];
          n_del++;
        end
        n_part = 0;
      end
    end
  end

  function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [15:0] d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int b = 15; b >= 0; b--) begin
      fb = c[15] ^ d[b];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Offer one flit, waiting for in_ready (R2 handshake).
  task automatic push(input logic [FW-1:0] f);
    int w;
    w = 0;
    while (!in_ready && w < 300) begin
      @(negedge clk);
      w++;
    end
    in_valid = 1'b1;
    in_flit  = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Build a packet per R4 and record it as expected delivery.
  task automatic send_pkt(input int id, input int nbody, output logic [FW-1:0] head_f);
    logic [15:0]   c;
    logic [15:0]   d;
    logic [FW-1:0] f;
    d = 16'(id * 16'h0101);
    c = ref_crc(16'hFFFF, d);
    f = {2'b01, d};
    head_f = f;
    exp_q[n_exp % 256] = f; n_exp++;
    push(f);
    for (int k = 0; k < nbody; k++) begin
      d = 16'(id * 16'h0111 + k * 16'h0013 + 7);
      c = ref_crc(c, d);
      f = {2'b00, d};
      exp_q[n_exp % 256] = f; n_exp++;
      push(f);
    end
    f = {2'b10, c};
    exp_q[n_exp % 256] = f; n_exp++;
    push(f);
  endtask

  task automatic check_delivery(input string tag);
    int bad;
    bad = -1;
    chk(n_del == n_exp, {tag, " delivered flit count"}, 32'(n_del), 32'(n_exp));
    for (int k = 0; k < n_exp && k < n_del; k++) begin
      if (bad < 0 && del_q[k] !== exp_q[k]) bad = k;
    end
    chk(bad < 0, {tag, " delivered content and order"},
        (bad < 0) ? 32'h0 : 32'(del_q[bad]), (bad < 0) ? 32'h0 : 32'(exp_q[bad]));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_flit = '0; sw_grant = 1'b0;
    pipe_upset = '0; glob_err = 1'b0;
    tick(3);
    chk(in_ready == 1'b1, "R1 in_ready during reset", 32'(in_ready), 32'h1);
    rst_n = 1'b1;
    tick(4);
    mon_on = 1'b1;
    #3;
    chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'h1);
    chk({out_valid, out_commit, out_drop, crc_err} == 4'b0, "R1 outputs idle",
        32'({out_valid, out_commit, out_drop, crc_err}), 32'h0);
  endtask

  task automatic t_latency;
    logic [FW-1:0] h;
    @(negedge clk);
    sw_grant = 1'b0;
    send_pkt(1, 1, h);
    sw_grant = 1'b1;
    repeat (PIPE - 1) @(negedge clk);
    #3;
    chk(out_valid == 1'b0, "R3 no output before PIPE edges", 32'(out_valid), 32'h0);
    @(negedge clk);
    #3;
    chk(out_valid == 1'b1 && out_flit == h, "R3 head on output after PIPE edges",
        32'(out_flit), 32'(h));
    tick(12);
    chk(n_err == 0, "R5 no error on clean packet", 32'(n_err), 32'h0);
    check_delivery("R4 R5 clean packet");
  endtask

  task automatic t_fill;
    logic [FW-1:0] h;
    @(negedge clk);
    sw_grant = 1'b0;
    for (int p = 0; p < 5; p++) send_pkt(10 + p, 1, h);
    #3;
    chk(in_ready == 1'b0, "R2 back-pressure at DEPTH-1 flits", 32'(in_ready), 32'h0);
    @(negedge clk);
    in_valid = 1'b1;
    in_flit  = {2'b01, 16'hDEAD};
    tick(3);
    in_valid = 1'b0;
    sw_grant = 1'b1;
    @(negedge clk);
    #3;
    chk(in_ready == 1'b0, "R9 launched flits still held", 32'(in_ready), 32'h0);
    tick(40);
    #3;
    chk(in_ready == 1'b1, "R5 slots freed after commits", 32'(in_ready), 32'h1);
    check_delivery("R2 R3 full buffer drain, refused flit absent");
  endtask

  task automatic t_upset;
    logic [FW-1:0] hb, hc;
    int log0, err0, w;
    @(negedge clk);
    sw_grant = 1'b0;
    send_pkt(30, 2, hb);
    send_pkt(31, 1, hc);
    log0 = n_log;
    err0 = n_err;
    sw_grant   = 1'b1;
    pipe_upset = 16'h0040;
    @(negedge clk);
    pipe_upset = '0;
    w = 0;
    #3;
    while (!crc_err && w < 50) begin
      @(negedge clk);
      #3;
      w++;
    end
    chk(crc_err == 1'b1 && out_drop == 1'b1 && out_commit == 1'b0,
        "R6 mismatch raises error and drop without commit",
        32'({crc_err, out_drop, out_commit}), 32'b110);
    @(negedge clk);
    #3;
    chk(out_valid == 1'b0, "R7 pipeline empty after rewind", 32'(out_valid), 32'h0);
    chk(crc_err == 1'b0, "R6 error lasts one cycle", 32'(crc_err), 32'h0);
    tick(40);
    chk(log_q[log0 % 512] == {hb[FW-1:DW], hb[DW-1:0] ^ 16'h0040},
        "R10 upset mask applied to launched flit", 32'(log_q[log0 % 512]),
        32'({hb[FW-1:DW], hb[DW-1:0] ^ 16'h0040}));
    chk(n_err - err0 == 1, "R6 single error for single upset", 32'(n_err - err0), 32'h1);
    check_delivery("R7 R11 replay after upset");
  endtask

  task automatic t_global;
    logic [FW-1:0] h;
    int err0, w;
    @(negedge clk);
    sw_grant = 1'b1;
    err0 = n_err;
    send_pkt(40, 1, h);
    w = 0;
    #3;
    while (!(out_valid && out_flit[FW-1:DW] == 2'b10) && w < 50) begin
      @(negedge clk);
      #3;
      w++;
    end
    glob_err = 1'b1;
    #1;
    chk(out_drop == 1'b1 && out_commit == 1'b0, "R8 broadcast drops matching tail",
        32'({out_drop, out_commit}), 32'b10);
    @(negedge clk);
    glob_err = 1'b0;
    tick(30);
    chk(n_err == err0, "R8 broadcast raises no local error", 32'(n_err), 32'(err0));
    check_delivery("R8 R11 packet replayed once after broadcast");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_fill();
    t_upset();
    t_global();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule